// File: doc/BRIEF.md
# Debug Power Request Controller

This block sits between an external debug port and the power controller of one processor core. A debugger uses a small register window to ask for the core's power domain to be switched on and to forbid it from being switched off while a debug session is under way. The block turns those register bits into two registered request lines toward the power controller. It takes back a powered-up acknowledge, brings it through a two-flop synchronizer, and reports it in a read-only status register.

The same window holds an OS lock and a double-lock flag. Together with the synchronized power state, they decide whether a register that lives inside the core power domain may be touched. A refused access returns an error with zero read data and changes nothing. If the core tries to power down while the no-power-down request is held, the block records a sticky "emulated power-down" flag instead of letting the event pass unseen. The data register inside the core domain loses its contents whenever the domain is reported unpowered.

Top module: `dbg_pwr_gate`

## Requirements
- R1: After reset, both request outputs are low, the OS lock is set, the double lock is clear, the powered status is 0 and no response is valid.
- R2: A write to byte offset 0x310 sets the power-up request from data bit 3 and the no-power-down request from data bit 0. The outputs `pwrUpReq` and `noPwrDnReq` follow from the clock edge that accepts the write, and a read of 0x310 returns the two bits in those positions.
- R3: Bit 0 of the read-only status at offset 0x314 is `pwrAck` delayed by two flops. It stays 0 while the acknowledge is low, and a read accepted at the first edge after the acknowledge rises still returns 0.
- R4: A write to offset 0x304 sets the double lock from data bit 0. A read of 0x304 returns it in bit 0, and status bit 6 shows it.
- R5: A write to offset 0x300 with data bit 0 equal to 0 clears the OS lock, and with data bit 0 equal to 1 sets it. Status bit 5 shows the OS lock, and a read of 0x300 returns 0.
- R6: The core-domain data register at offset 0x0A0 (32 bits, read/write) may be accessed only while the powered status is 1, the double lock is clear and the OS lock is clear. Any other access to it gets an error with zero read data, and a refused write leaves the register unchanged.
- R7: Each accepted access gets exactly one response one cycle later. An access to any offset not named here gets an error with zero read data.
- R8: When `coreDownReq` is high while the no-power-down request is set, status bit 1 becomes 1 and stays set until a status read clears it. The read that clears it returns 1. When `coreDownReq` is high without the no-power-down request, bit 1 is not set.
- R9: When the powered status falls, the core-domain data register reads back 0 once power returns. A repeated power-up request after a drop restores the powered status when the acknowledge returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access request for this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 12 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRespValid | output | 1 | Response valid, one cycle after the access |
| busRdata | output | 32 | Read data, zero on error |
| busErr | output | 1 | Access refused or unmapped |
| pwrUpReq | output | 1 | Registered power-up request to the power controller |
| noPwrDnReq | output | 1 | Registered no-power-down request to the power controller |
| pwrAck | input | 1 | Powered-up acknowledge from the power controller (asynchronous) |
| coreDownReq | input | 1 | Core attempt to enter a powered-down state |

## Verification
A vector table walks reads and writes over every mapped offset and one unmapped one while the core is unpowered. This separates address decode, readback positions and the error path from anything power-dependent. Directed sequences then raise the acknowledge and read the status on consecutive accesses, which exposes a synchronizer that is too short or too long. The core-domain register is accessed under each single blocking condition (no power, double lock, OS lock) so that each term of the permission gate is tested alone. Power-down attempts are made with and without the no-power-down request. A final step drops and restores the acknowledge to show that the register contents are lost and that a retried request brings the domain back.

// File: rtl/dbg_pwr_pkg.sv
package dbg_pwr_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_OSLK  = 12'h300;
  localparam logic [ADDR_W-1:0] OFS_DLK   = 12'h304;
  localparam logic [ADDR_W-1:0] OFS_CTL   = 12'h310;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h314;

  localparam int CTL_UP_BIT   = 3;
  localparam int CTL_NPD_BIT  = 0;
  localparam int ST_PWR_BIT   = 0;
  localparam int ST_EMU_BIT   = 1;
  localparam int ST_OSLK_BIT  = 5;
  localparam int ST_DLK_BIT   = 6;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_STAT, SEL_DLK, SEL_DATA
  } rdSel_e;

  typedef struct packed {
    logic   wrCtl;
    logic   wrOsLock;
    logic   wrDLock;
    logic   wrData;
    logic   rdStat;
    logic   err;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/dbg_pwr_ctrl.sv
module dbg_pwr_ctrl
  import dbg_pwr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic          poweredSt,
  input  logic          dLock,
  input  logic          osLock,
  output strobe_t       strb
);
  logic coreAccessOk;

  assign coreAccessOk = poweredSt && !dLock && !osLock;

  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    if (busValid) begin
      unique case (busAddr)
        OFS_DATA: begin
          if (coreAccessOk) begin
            strb.wrData = busWrite;
            strb.rdSel  = busWrite ? SEL_NONE : SEL_DATA;
          end else begin
            strb.err = 1'b1;
          end
        end
        OFS_OSLK: strb.wrOsLock = busWrite;
        OFS_DLK: begin
          strb.wrDLock = busWrite;
          strb.rdSel   = busWrite ? SEL_NONE : SEL_DLK;
        end
        OFS_CTL: begin
          strb.wrCtl = busWrite;
          strb.rdSel = busWrite ? SEL_NONE : SEL_CTL;
        end
        OFS_STAT: begin
          strb.rdStat = !busWrite;
          strb.rdSel  = busWrite ? SEL_NONE : SEL_STAT;
        end
        default: strb.err = 1'b1;
      endcase
    end
  end

  // R6: a core-domain write strobe only ever leaves while access is permitted
  assert_gate_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |-> (poweredSt && !dLock && !osLock));

  // R7: unmapped offsets never produce a write strobe
  assert_unmapped_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busAddr != OFS_DATA && busAddr != OFS_OSLK && busAddr != OFS_DLK
     && busAddr != OFS_CTL && busAddr != OFS_STAT)
    |-> (strb.err && !strb.wrCtl && !strb.wrOsLock && !strb.wrDLock && !strb.wrData));
endmodule

// File: rtl/dbg_pwr_dp.sv
module dbg_pwr_dp
  import dbg_pwr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic          busValid,
  input  logic [DW-1:0] busWdata,
  input  logic          pwrAck,
  input  logic          coreDownReq,
  output logic          poweredSt,
  output logic          dLock,
  output logic          osLock,
  output logic          pwrUpReq,
  output logic          noPwrDnReq,
  output logic          busRespValid,
  output logic [DW-1:0] busRdata,
  output logic          busErr
);
  logic [SYNC_STAGES-1:0] ackSync;
  logic                   emuDown;
  logic [DW-1:0]          dataReg;
  logic [DW-1:0]          rdMux;

  assign poweredSt = ackSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) ackSync <= '0;
    else       ackSync <= {ackSync[SYNC_STAGES-2:0], pwrAck};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrUpReq   <= 1'b0;
      noPwrDnReq <= 1'b0;
      osLock     <= 1'b1;
      dLock      <= 1'b0;
      emuDown    <= 1'b0;
      dataReg    <= '0;
    end else begin
      if (strb.wrCtl) begin
        pwrUpReq   <= busWdata[CTL_UP_BIT];
        noPwrDnReq <= busWdata[CTL_NPD_BIT];
      end
      if (strb.wrOsLock) osLock <= busWdata[0];
      if (strb.wrDLock)  dLock  <= busWdata[0];
      if (coreDownReq && noPwrDnReq) emuDown <= 1'b1;
      else if (strb.rdStat)          emuDown <= 1'b0;
      if (!poweredSt)       dataReg <= '0;
      else if (strb.wrData) dataReg <= busWdata;
    end
  end

  always_comb begin
    rdMux = '0;
    unique case (strb.rdSel)
      SEL_CTL: begin
        rdMux[CTL_UP_BIT]  = pwrUpReq;
        rdMux[CTL_NPD_BIT] = noPwrDnReq;
      end
      SEL_STAT: begin
        rdMux[ST_PWR_BIT]  = poweredSt;
        rdMux[ST_EMU_BIT]  = emuDown;
        rdMux[ST_OSLK_BIT] = osLock;
        rdMux[ST_DLK_BIT]  = dLock;
      end
      SEL_DLK:  rdMux[0] = dLock;
      SEL_DATA: rdMux = dataReg;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRespValid <= 1'b0;
      busRdata     <= '0;
      busErr       <= 1'b0;
    end else begin
      busRespValid <= busValid;
      busErr       <= busValid && strb.err;
      busRdata     <= (busValid && !strb.err) ? rdMux : '0;
    end
  end

  // R3: the powered status can rise only for an acknowledge seen two edges before
  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(poweredSt) |-> $past(pwrAck, 2));

  // R6 and R7: an error response always carries zero data
  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busRdata == '0 && busRespValid));

  // R8: the sticky flag only rises on a blocked power-down attempt
  assert_emu_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(emuDown) |-> $past(coreDownReq && noPwrDnReq));

  // R2: request outputs change only through a control write
  assert_req_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrCtl) |-> ($stable(pwrUpReq) && $stable(noPwrDnReq)));
endmodule

// File: rtl/dbg_pwr_gate.sv
module dbg_pwr_gate
  import dbg_pwr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busValid,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic          busRespValid,
  output logic [DW-1:0] busRdata,
  output logic          busErr,
  output logic          pwrUpReq,
  output logic          noPwrDnReq,
  input  logic          pwrAck,
  input  logic          coreDownReq
);
  strobe_t strb;
  logic    poweredSt;
  logic    dLock;
  logic    osLock;

  dbg_pwr_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .poweredSt (poweredSt),
    .dLock     (dLock),
    .osLock    (osLock),
    .strb      (strb)
  );

  dbg_pwr_dp #(.DW(DW), .SYNC_STAGES(2)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busValid     (busValid),
    .busWdata     (busWdata),
    .pwrAck       (pwrAck),
    .coreDownReq  (coreDownReq),
    .poweredSt    (poweredSt),
    .dLock        (dLock),
    .osLock       (osLock),
    .pwrUpReq     (pwrUpReq),
    .noPwrDnReq   (noPwrDnReq),
    .busRespValid (busRespValid),
    .busRdata     (busRdata),
    .busErr       (busErr)
  );
endmodule

// File: tb/dbg_pwr_gate_bench.sv
module dbg_pwr_gate_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busRespValid;
  logic [31:0] busRdata;
  logic        busErr;
  logic        pwrUpReq;
  logic        noPwrDnReq;
  logic        pwrAck = 1'b0;
  logic        coreDownReq = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_pwr_gate u_dbg_pwr_gate (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRespValid(busRespValid),
    .busRdata(busRdata), .busErr(busErr), .pwrUpReq(pwrUpReq),
    .noPwrDnReq(noPwrDnReq), .pwrAck(pwrAck), .coreDownReq(coreDownReq)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] expData;
    logic        expErr;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h314, 32'h0, 32'h20, 1'b0},  // R5 OS lock set at reset
    '{1'b1, 12'h310, 32'h9, 32'h0,  1'b0},  // R2 write both requests
    '{1'b0, 12'h310, 32'h0, 32'h9,  1'b0},  // R2 readback
    '{1'b0, 12'h0A0, 32'h0, 32'h0,  1'b1},  // R6 unpowered read refused
    '{1'b1, 12'h0A0, 32'h5, 32'h0,  1'b1},  // R6 unpowered write refused
    '{1'b0, 12'h200, 32'h0, 32'h0,  1'b1},  // R7 unmapped read
    '{1'b1, 12'h318, 32'h1, 32'h0,  1'b1},  // R7 unmapped write
    '{1'b1, 12'h304, 32'h1, 32'h0,  1'b0},  // R4 set double lock
    '{1'b0, 12'h304, 32'h0, 32'h1,  1'b0},  // R4 readback
    '{1'b0, 12'h314, 32'h0, 32'h60, 1'b0},  // R4 status bit 6
    '{1'b1, 12'h304, 32'h0, 32'h0,  1'b0},  // R4 clear double lock
    '{1'b1, 12'h300, 32'h0, 32'h0,  1'b0},  // R5 clear OS lock
    '{1'b0, 12'h300, 32'h0, 32'h0,  1'b0},  // R5 reads zero
    '{1'b0, 12'h314, 32'h0, 32'h0,  1'b0},  // R5 status bit 5 clear
    '{1'b1, 12'h310, 32'h0, 32'h0,  1'b0}   // R2 clear requests
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic err);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = wd;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0;
    rd = busRdata;
    err = busErr;
    checks++;
    if (busRespValid !== 1'b1) begin
      errors++;
      $display("FAIL R7 response missing actual=%b expected=1", busRespValid);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    idle(3);
    // R1 reset state at the ports
    check("R1 pwrUpReq", {31'b0, pwrUpReq}, 32'h0);
    check("R1 noPwrDnReq", {31'b0, noPwrDnReq}, 32'h0);
    check("R1 respValid", {31'b0, busRespValid}, 32'h0);
    rstN = 1'b1;
    idle(1);
    check("R1 respValid idle", {31'b0, busRespValid}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].wr, VECS[v].addr, VECS[v].wdata, rd, er);
      check($sformatf("R7 vec%0d err", v), {31'b0, er}, {31'b0, VECS[v].expErr});
      if (!VECS[v].wr || VECS[v].expErr)
        check($sformatf("R6 vec%0d data", v), rd, VECS[v].expData);
    end

    // R2 outputs follow the write
    access(1'b1, 12'h310, 32'h8, rd, er);
    check("R2 pwrUpReq set", {31'b0, pwrUpReq}, 32'h1);
    check("R2 noPwrDnReq clear", {31'b0, noPwrDnReq}, 32'h0);

    // R3 status holds low until the acknowledge
    idle(5);
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R3 no ack", rd & 32'h1, 32'h0);
    @(negedge clk);
    pwrAck = 1'b1;
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R3 first read after ack", rd & 32'h1, 32'h0);
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R3 second read after ack", rd & 32'h1, 32'h1);

    // R6 permitted access, then each blocking term on its own
    access(1'b1, 12'h0A0, 32'hDEADBEEF, rd, er);
    check("R6 permitted write err", {31'b0, er}, 32'h0);
    access(1'b0, 12'h0A0, 32'h0, rd, er);
    check("R6 permitted read", rd, 32'hDEADBEEF);
    access(1'b1, 12'h304, 32'h1, rd, er);
    access(1'b1, 12'h0A0, 32'h12345678, rd, er);
    check("R6 dlock write err", {31'b0, er}, 32'h1);
    access(1'b0, 12'h0A0, 32'h0, rd, er);
    check("R6 dlock read zero", rd, 32'h0);
    access(1'b1, 12'h304, 32'h0, rd, er);
    access(1'b1, 12'h300, 32'h1, rd, er);
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R5 OS lock set again", rd, 32'h21);
    access(1'b0, 12'h0A0, 32'h0, rd, er);
    check("R6 oslock read err", {31'b0, er}, 32'h1);
    access(1'b1, 12'h300, 32'h0, rd, er);
    access(1'b0, 12'h0A0, 32'h0, rd, er);
    check("R6 refused write left value", rd, 32'hDEADBEEF);

    // R8 emulated power-down
    access(1'b1, 12'h310, 32'h9, rd, er);
    check("R2 noPwrDnReq set", {31'b0, noPwrDnReq}, 32'h1);
    @(negedge clk); coreDownReq = 1'b1;
    @(negedge clk); coreDownReq = 1'b0;
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R8 sticky set", rd & 32'h2, 32'h2);
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R8 cleared by read", rd & 32'h2, 32'h0);
    access(1'b1, 12'h310, 32'h8, rd, er);
    @(negedge clk); coreDownReq = 1'b1;
    @(negedge clk); coreDownReq = 1'b0;
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R8 no set without npd", rd & 32'h2, 32'h0);

    // R9 power drop and retry
    @(negedge clk); pwrAck = 1'b0;
    idle(4);
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R9 powered dropped", rd & 32'h1, 32'h0);
    access(1'b0, 12'h0A0, 32'h0, rd, er);
    check("R9 refused while down", {31'b0, er}, 32'h1);
    access(1'b1, 12'h310, 32'h8, rd, er);
    check("R9 retry request", {31'b0, pwrUpReq}, 32'h1);
    @(negedge clk); pwrAck = 1'b1;
    idle(4);
    access(1'b0, 12'h314, 32'h0, rd, er);
    check("R9 powered again", rd & 32'h1, 32'h1);
    access(1'b0, 12'h0A0, 32'h0, rd, er);
    check("R9 contents lost", rd, 32'h0);
    check("R9 err after restore", {31'b0, er}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule